// File: doc/BRIEF.md
# Carry-Strobe Interval Timer

The block paces periodic work, such as sampling a synthesizer output, with a single-clock strobe. It keeps a 32-bit accumulator that grows by a programmed step on every clock. The strobe is the carry out of that addition, so the interval is set as a fraction of the clock rate. For a wanted interval T and clock period Tclk, the step is 2^32 * Tclk / T. The strobe rate averages step / 2^32 of the clock rate, and the period may be fractional, not a whole number of cycles.

The step comes in on a data bus and is held in a step register. An active-low capture enable loads it. An active-low feedback-clear control removes the accumulator's own value from the sum. While that control is low, the accumulator takes the bare step value and the strobe stays quiet. Releasing the control therefore starts the timer from a known phase.

Top module: `carry_interval_timer`

## Requirements
- R1: A synchronous active-low reset clears the step register, the accumulator and the strobe. After reset with no capture, the strobe stays low.
- R2: On a rising clock edge where `cap_n` is low, the step register takes `step_in`. When `cap_n` is high, changes on `step_in` have no effect on the strobe pattern.
- R3: While `fbclr_n` is high, each clock edge adds the held step to the accumulator modulo 2^32. The strobe is the carry out of that addition and appears one cycle later as a one-clock pulse.
- R4: While `fbclr_n` is low, the accumulator loads the held step value and the strobe is low on the following cycle.
- R5: After the phase is set with `fbclr_n` low, N cycles of running give exactly floor((N+1)*step / 2^32) strobes. For a step of 2^30, that is one strobe every 4 cycles.
- R6: A step of 0 produces no strobe. A step of 2^31 produces a strobe on every second cycle.
- R7: A newly captured step is used starting with the clock edge after the one that captured it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| step_in | input | 32 | Step value to capture |
| cap_n | input | 1 | Step capture enable, active low |
| fbclr_n | input | 1 | Accumulator feedback clear, active low |
| strobe | output | 1 | Registered carry-out pulse |

## Verification
The hardest case to reach from the ports is a fractional interval whose strobe spacing alternates between two lengths. Only a strobe count over a long run shows that this spacing is right. The stimulus first sets the phase with `fbclr_n` low. It then runs thousands of cycles with a step that does not divide 2^32 and compares the strobe count with the closed-form count. A per-cycle scoreboard also follows the exact pulse positions while the step, the capture enable and the feedback clear change in the middle of a run.

// File: rtl/tmr_pkg.sv
// Package: shared definitions for the carry-strobe interval timer.
// Assumes a single clock domain; widths are set through parameters.
package tmr_pkg;
    localparam int ACC_W_DEF = 32;

    // Accumulator feedback selection
    typedef enum logic {
        FB_CLEAR = 1'b0,
        FB_RUN   = 1'b1
    } fb_mode_e;
endpackage

// File: rtl/tmr_step_reg.sv
// Module: holds the programmed step value.
// Loads from the data input while the active-low capture enable is low;
// cleared by the synchronous active-low reset.
module tmr_step_reg #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cap_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] step_q
);
    // Capture or hold the step value
    always_ff @(posedge clk) begin
        if (!rst_n)
            step_q <= '0;
        else if (!cap_n)
            step_q <= din;
    end
endmodule

// File: rtl/tmr_phase_acc.sv
// Module: phase accumulator with a clearable feedback path.
// Computes feedback + step with one extra carry bit and registers the sum.
// Assumes the step is already registered upstream.
module tmr_phase_acc #(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_pkg::fb_mode_e fb_mode,
    input  logic [W-1:0]     step,
    output logic [W-1:0]     acc_q,
    output logic             carry
);
    localparam int SW = W + 1;

    logic [W-1:0]  feedback;
    logic [SW-1:0] sum;

    // Select accumulator feedback or zero
    always_comb begin
        feedback = (fb_mode == tmr_pkg::FB_RUN) ? acc_q : '0;
    end

    // Wide addition that exposes the carry
    always_comb begin
        sum = {1'b0, feedback} + {1'b0, step};
    end

    assign carry = sum[SW-1];

    // Register the truncated sum
    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else
            acc_q <= sum[W-1:0];
    end
endmodule

// File: rtl/tmr_strobe_reg.sv
// Module: registers the accumulator carry as a one-clock strobe.
// Forces the strobe low while feedback is cleared.
module tmr_strobe_reg (
    input  logic              clk,
    input  logic              rst_n,
    input  tmr_pkg::fb_mode_e fb_mode,
    input  logic              carry,
    output logic              strobe
);
    // Register the qualified carry
    always_ff @(posedge clk) begin
        if (!rst_n)
            strobe <= 1'b0;
        else
            strobe <= carry && (fb_mode == tmr_pkg::FB_RUN);
    end
endmodule

// File: rtl/carry_interval_timer.sv
// Top: carry-strobe interval timer.
// The step register feeds a phase accumulator; the registered carry out is
// the timing strobe. Single clock, synchronous active-low reset.
module carry_interval_timer #(
    parameter int ACC_W = tmr_pkg::ACC_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [ACC_W-1:0] step_in,
    input  logic             cap_n,
    input  logic             fbclr_n,
    output logic             strobe
);
    logic [ACC_W-1:0]  step_q;
    logic [ACC_W-1:0]  acc_q;
    logic              carry;
    tmr_pkg::fb_mode_e fb_mode;

    // Decode the feedback control
    always_comb begin
        fb_mode = fbclr_n ? tmr_pkg::FB_RUN : tmr_pkg::FB_CLEAR;
    end

    tmr_step_reg #(.W(ACC_W)) u_step (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_n  (cap_n),
        .din    (step_in),
        .step_q (step_q)
    );

    tmr_phase_acc #(.W(ACC_W)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .fb_mode (fb_mode),
        .step    (step_q),
        .acc_q   (acc_q),
        .carry   (carry)
    );

    tmr_strobe_reg u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .fb_mode (fb_mode),
        .carry   (carry),
        .strobe  (strobe)
    );
endmodule

// File: rtl/tmr_checker.sv
// Checker: temporal properties of the carry-strobe interval timer,
// bound to the top module.
module tmr_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         cap_n,
    input logic         fbclr_n,
    input logic [W-1:0] step_in,
    input logic [W-1:0] step_q,
    input logic [W-1:0] acc_q,
    input logic         strobe
);
    a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_n |=> step_q == $past(step_in));

    a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
        cap_n |=> step_q == $past(step_q));

    a_r3_accumulate: assert property (@(posedge clk) disable iff (!rst_n)
        fbclr_n |=> acc_q == W'($past(acc_q) + $past(step_q)));

    a_r3_carry: assert property (@(posedge clk) disable iff (!rst_n)
        fbclr_n |=> strobe == (({1'b0, $past(acc_q)} + {1'b0, $past(step_q)}) > {1'b0, {W{1'b1}}}));

    a_r4_load_step: assert property (@(posedge clk) disable iff (!rst_n)
        !fbclr_n |=> acc_q == $past(step_q));

    a_r4_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !fbclr_n |=> !strobe);

    a_r6_zero_step: assert property (@(posedge clk) disable iff (!rst_n)
        (step_q == '0) |=> !strobe);
endmodule

bind carry_interval_timer tmr_checker #(.W(ACC_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cap_n   (cap_n),
    .fbclr_n (fbclr_n),
    .step_in (step_in),
    .step_q  (step_q),
    .acc_q   (acc_q),
    .strobe  (strobe)
);

// File: tb/tb_carry_interval_timer.sv
// Scoreboard bench: the driver predicts the strobe from the requirements,
// and the monitor compares it 2 ns after each rising edge.
module tb_carry_interval_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] step_in = '0;
    logic        cap_n = 1'b1;
    logic        fbclr_n = 1'b1;
    logic        strobe;

    typedef struct {
        logic  exp;
        string req;
    } item_t;

    item_t q[$];
    int checks = 0;
    int errors = 0;
    int seen = 0;
    logic [31:0] m_step = '0;
    logic [31:0] m_acc = '0;

    always #4 clk = ~clk;

    carry_interval_timer dut (
        .clk(clk), .rst_n(rst_n), .step_in(step_in),
        .cap_n(cap_n), .fbclr_n(fbclr_n), .strobe(strobe)
    );

    // Driver: apply one cycle of inputs and push the predicted strobe
    task automatic drive(input logic r, input logic c, input logic f,
                         input logic [31:0] d, input string req);
        logic [32:0] s;
        item_t it;
        @(negedge clk);
        rst_n = r; cap_n = c; fbclr_n = f; step_in = d;
        s = {1'b0, (f ? m_acc : 32'd0)} + {1'b0, m_step};
        if (!r) begin
            it.exp = 1'b0; m_acc = '0; m_step = '0;
        end else begin
            it.exp = f & s[32];
            m_acc = s[31:0];
            if (!c) m_step = d;
        end
        it.req = req;
        q.push_back(it);
    endtask

    task automatic run(input int n, input logic [31:0] d, input string req);
        for (int i = 0; i < n; i++) drive(1'b1, 1'b1, 1'b1, d, req);
    endtask

    // Monitor: pop and compare after each rising edge
    always @(posedge clk) begin
        #2;
        if (q.size() > 0) begin
            item_t it;
            it = q.pop_front();
            checks++;
            if (strobe) seen++;
            if (strobe !== it.exp) begin
                errors++;
                $display("FAIL %s strobe actual=%0b expected=%0b", it.req, strobe, it.exp);
            end
        end
    end

    task automatic drain();
        @(posedge clk); #3;
    endtask

    // Watchdog
    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        longint exp_cnt;
        // R1: reset ignores a capture request and keeps the strobe low
        for (int i = 0; i < 3; i++) drive(1'b0, 1'b0, 1'b1, 32'hFFFF_FFFF, "R1");
        // R1: step cleared, so nothing fires
        run(4, 32'hFFFF_FFFF, "R1");
        // R5: step 2^30, set phase, then every 4th cycle
        drive(1'b1, 1'b0, 1'b0, 32'h4000_0000, "R4");
        drive(1'b1, 1'b1, 1'b0, 32'h0, "R4");
        run(16, 32'h0, "R5");
        // R2: changing data with capture disabled is ignored
        run(8, 32'hDEAD_BEEF, "R2");
        // R7: capture 2^31; new step applies from the following edge
        drive(1'b1, 1'b0, 1'b1, 32'h8000_0000, "R7");
        run(10, 32'h1234_5678, "R6");
        // R4: feedback clear quiets the strobe and reloads the phase
        drive(1'b1, 1'b1, 1'b0, 32'h0, "R4");
        drive(1'b1, 1'b1, 1'b0, 32'h0, "R4");
        drive(1'b1, 1'b1, 1'b0, 32'h0, "R4");
        run(6, 32'h0, "R6");
        // R3: near-full step fires almost every cycle
        drive(1'b1, 1'b0, 1'b1, 32'hFFFF_FFFF, "R3");
        run(12, 32'h0, "R3");
        // R6: zero step never fires
        drive(1'b1, 1'b0, 1'b1, 32'h0, "R6");
        run(12, 32'h0, "R6");
        // R5: fractional interval, closed-form strobe count
        drive(1'b1, 1'b0, 1'b0, 32'h0A3D_70A4, "R4");
        drive(1'b1, 1'b1, 1'b0, 32'h0, "R4");
        drain();
        seen = 0;
        run(3000, 32'h0, "R5");
        drain();
        exp_cnt = (longint'(3001) * longint'(32'h0A3D_70A4)) >>> 32;
        checks++;
        if (longint'(seen) != exp_cnt) begin
            errors++;
            $display("FAIL R5 strobe count actual=%0d expected=%0d", seen, exp_cnt);
        end
        // R1: reset mid-run clears everything again
        drive(1'b0, 1'b1, 1'b1, 32'h0, "R1");
        run(6, 32'h0, "R1");
        drain();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule